// File: doc/BRIEF.md
# Buffered Period and Compare Timer

This block is a timer counter core with double-buffered period and compare values. It has one active target (period) register and one active compare register per channel. Each of these has a pending register in front of it. Software writes the pending copy. The core moves that copy into the active register on the tick that takes the counter down to zero, so a change of PWM period or duty never lands in the middle of a period. A mode write restarts the timer and discards any queued load.

Three counting modes exist: count up once and stop at the target, count up and wrap, and count up and down between zero and the target. The counter moves only on clock cycles where the tick enable is high. The core raises a target flag, a zero flag, one compare flag per channel and a one-cycle compare event per channel. Register access through the normal addresses clears the flags that belong to that register. The no-clear alias addresses reach the same storage but leave the flags alone.

Top module: `buf_tmr`

## Requirements
- R1: The pending target is copied into the active target on a tick that moves the counter from a nonzero value to 0. The copy happens only if the pending target was written since the last copy.
- R2: A mode write never copies pending values into active registers. It discards every queued target and compare load, although the pending register contents stay in place.
- R3: A pending compare value is copied into its active compare register on the same zero-crossing tick as R1. The copy happens only if that pending value was written. In disabled mode the counter holds and no copy takes place.
- R4: Mode encoding is 0 disabled, 1 up-once, 2 up-wrap and 3 up/down. After reset the mode is disabled, the counter is 0, all registers and flags are 0, and the direction is up. A mode write to 1, 2 or 3 restarts the counter at 0 counting up.
- R5: In mode 2 the counter counts 0 up to the active target, then returns to 0. In mode 3 it reverses at the target and again at 0. `dir_down_o` is 1 while it counts down and is 0 in every other mode.
- R6: In mode 1 the counter stops at the active target.
- R7: A tick in a non-disabled mode sets `tgt_flag_o` if the counter equals the active target at that tick. It sets `zero_flag_o` if the counter equals 0 at that tick.
- R8: Address layout: bit 3 set selects the no-clear alias. The low three bits select the register: 0 active target, 1 pending target, 2 to 4 active compare of channels 0 to 2, 5 to 7 pending compare of channels 0 to 2. A read or write of index 0 or 1 with bit 3 clear clears both the target flag and the zero flag. The same access with bit 3 set leaves them unchanged. A flag set on the same edge wins over a clear.
- R9: If a tick finds the counter equal to a channel's active compare value, that channel's `cmp_evt_o` bit pulses for one clock on the next tick, and the same edge sets its `cmp_flag_o` bit. An access to that channel's index 2+i or 5+i with bit 3 clear clears the flag; the alias does not.
- R10: The counter changes only on a mode write or on a cycle where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 2 | Mode value written by mode_wr |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register index with no-clear alias in bit 3 |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Register read data (combinational) |
| cnt_o | output | CNT_W | Current counter value |
| dir_down_o | output | 1 | Counter is counting down |
| tgt_flag_o | output | 1 | Target match flag |
| zero_flag_o | output | 1 | Zero flag |
| cmp_flag_o | output | NCH | Compare flags per channel |
| cmp_evt_o | output | NCH | One-cycle compare events per channel |

## Verification
The bench builds the block with its defaults, a 16-bit counter and three channels. Small targets of 0 to 6 then reach every wrap, reversal and stop point within a few ticks. With three channels, a flag access on one channel can be checked alongside loads on the other two. The target value of 0 in up/down mode checks that the reversal logic does not leave zero. Channel addresses fill the three-bit index exactly, so the alias bit sits at bit 3.

// File: rtl/buf_tmr_pkg.sv
// Shared types for the buffered timer: the counting mode encoding.
package buf_tmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_ONCE = 2'd1,
        MODE_WRAP = 2'd2,
        MODE_TRI  = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/buf_tmr_count.sv
// Counter engine: holds the mode, the count and direction, and the target and
// zero flags. Assumes tgt_act is stable within a cycle; a mode write takes
// priority over a tick in the same cycle.
module buf_tmr_count
    import buf_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mode_wr,
    input  logic [1:0]       mode_val,
    input  logic [CNT_W-1:0] tgt_act,
    input  logic             clr_tz,
    output tmr_mode_e        mode_q,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             tick_run,
    output logic             zc,
    output logic             tgt_flag,
    output logic             zero_flag
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             dir_nxt;
    tmr_mode_e        mode_new;

    assign mode_new = tmr_mode_e'(mode_val);
    assign tick_run = tick_en && (mode_q != MODE_OFF) && !mode_wr;
    assign zc       = tick_run && (cnt_nxt == '0) && (cnt != '0);

    // Next count and direction for one tick in the current mode.
    always_comb begin
        cnt_nxt = cnt;
        dir_nxt = dir_down;
        case (mode_q)
            MODE_ONCE: cnt_nxt = (cnt >= tgt_act) ? cnt : cnt + 1'b1;
            MODE_WRAP: cnt_nxt = (cnt >= tgt_act) ? '0 : cnt + 1'b1;
            MODE_TRI: begin
                if (!dir_down) begin
                    if (cnt >= tgt_act) begin
                        dir_nxt = 1'b1;
                        cnt_nxt = (cnt == '0) ? '0 : cnt - 1'b1;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end else begin
                    if (cnt == '0) begin
                        dir_nxt = 1'b0;
                        cnt_nxt = (tgt_act == '0) ? '0 : CNT_W'(1);
                    end else begin
                        cnt_nxt = cnt - 1'b1;
                    end
                end
            end
            default: cnt_nxt = cnt;
        endcase
    end

    // Mode, counter and direction state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_OFF;
            cnt      <= '0;
            dir_down <= 1'b0;
        end else if (mode_wr) begin
            mode_q   <= mode_new;
            dir_down <= 1'b0;
            if (mode_new != MODE_OFF) cnt <= '0;
        end else if (tick_run) begin
            cnt      <= cnt_nxt;
            dir_down <= dir_nxt;
        end
    end

    // Target and zero flags: set by a tick at the match, cleared by access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_flag  <= 1'b0;
            zero_flag <= 1'b0;
        end else begin
            if (tick_run && (cnt == tgt_act)) tgt_flag <= 1'b1;
            else if (clr_tz)                  tgt_flag <= 1'b0;
            if (tick_run && (cnt == '0))      zero_flag <= 1'b1;
            else if (clr_tz)                  zero_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/buf_tmr_shadow.sv
// Active/pending register pair. The pending value moves to the active register
// on load only if it was written since the last move; flush forgets the write.
// Assumes load and flush never coincide (the counter gives mode writes priority).
module buf_tmr_shadow #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_act,
    input  logic             wr_pend,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    input  logic             flush,
    output logic [CNT_W-1:0] act,
    output logic [CNT_W-1:0] pend
);
    logic written;

    // Pending storage and its written marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            written <= 1'b0;
        end else begin
            if (wr_pend) pend <= wdata;
            if (flush)        written <= 1'b0;
            else if (wr_pend) written <= 1'b1;
            else if (load)    written <= 1'b0;
        end
    end

    // Active storage: a direct write wins over a buffered load.
    always_ff @(posedge clk) begin
        if (!rst_n)                     act <= '0;
        else if (wr_act)                act <= wdata;
        else if (load && written && !flush) act <= pend;
    end
endmodule

// File: rtl/buf_tmr_chan.sv
// One compare channel: buffered compare value, delayed match event and flag.
// Assumes tick_run already excludes disabled mode and mode-write cycles.
module buf_tmr_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick_run,
    input  logic             zc,
    input  logic             flush,
    input  logic             wr_act,
    input  logic             wr_pend,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] cc_act,
    output logic [CNT_W-1:0] cc_pend,
    output logic             evt,
    output logic             flag
);
    logic match_q;

    buf_tmr_shadow #(.CNT_W(CNT_W)) shadow_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_act (wr_act),
        .wr_pend(wr_pend),
        .wdata  (wdata),
        .load   (zc),
        .flush  (flush),
        .act    (cc_act),
        .pend   (cc_pend)
    );

    // Remember a match seen on a tick; report it on the following tick.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) match_q <= 1'b0;
        else if (tick_run)   match_q <= (cnt == cc_act);
    end

    // Event pulse and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt  <= 1'b0;
            flag <= 1'b0;
        end else begin
            evt <= tick_run && match_q;
            if (tick_run && match_q) flag <= 1'b1;
            else if (clr)            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/buf_tmr_regif.sv
// Register decode: write strobes, flag-clear strobes and read mux. The top
// address bit selects the no-clear alias of the same storage.
module buf_tmr_regif #(
    parameter int CNT_W  = 16,
    parameter int NCH    = 3,
    parameter int IDX_W  = 3
) (
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [IDX_W:0]            addr,
    input  logic [CNT_W-1:0]          tgt_act,
    input  logic [CNT_W-1:0]          tgt_pend,
    input  logic [NCH-1:0][CNT_W-1:0] cc_act,
    input  logic [NCH-1:0][CNT_W-1:0] cc_pend,
    output logic                      wr_tgt_act,
    output logic                      wr_tgt_pend,
    output logic [NCH-1:0]            wr_cc_act,
    output logic [NCH-1:0]            wr_cc_pend,
    output logic                      clr_tz,
    output logic [NCH-1:0]            clr_cc,
    output logic [CNT_W-1:0]          rdata
);
    logic [IDX_W-1:0] idx;
    logic             no_clr;
    logic             acc;

    assign idx    = addr[IDX_W-1:0];
    assign no_clr = addr[IDX_W];
    assign acc    = wr_en || rd_en;

    assign wr_tgt_act  = wr_en && (idx == IDX_W'(0));
    assign wr_tgt_pend = wr_en && (idx == IDX_W'(1));
    assign clr_tz      = acc && !no_clr && ((idx == IDX_W'(0)) || (idx == IDX_W'(1)));

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign wr_cc_act[i]  = wr_en && (idx == IDX_W'(2 + i));
        assign wr_cc_pend[i] = wr_en && (idx == IDX_W'(2 + NCH + i));
        assign clr_cc[i]     = acc && !no_clr &&
                               ((idx == IDX_W'(2 + i)) || (idx == IDX_W'(2 + NCH + i)));
    end

    // Read mux over all active and pending registers.
    always_comb begin
        rdata = '0;
        if (idx == IDX_W'(0)) rdata = tgt_act;
        if (idx == IDX_W'(1)) rdata = tgt_pend;
        for (int i = 0; i < NCH; i++) begin
            if (idx == IDX_W'(2 + i))       rdata = cc_act[i];
            if (idx == IDX_W'(2 + NCH + i)) rdata = cc_pend[i];
        end
    end
endmodule

// File: rtl/buf_tmr.sv
// Buffered period and compare timer top: counter engine, buffered target,
// NCH compare channels and register decode. Assumes one register access per
// cycle and that mode_wr is a single-cycle strobe.
module buf_tmr
    import buf_tmr_pkg::*;
#(
    parameter  int CNT_W  = 16,
    parameter  int NCH    = 3,
    localparam int IDX_W  = $clog2(2 + 2 * NCH),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              mode_wr,
    input  logic [1:0]        mode_val,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_down_o,
    output logic              tgt_flag_o,
    output logic              zero_flag_o,
    output logic [NCH-1:0]    cmp_flag_o,
    output logic [NCH-1:0]    cmp_evt_o
);
    tmr_mode_e                 mode_q;
    logic                      tick_run;
    logic                      zc;
    logic [CNT_W-1:0]          tgt_act;
    logic [CNT_W-1:0]          tgt_pend;
    logic [NCH-1:0][CNT_W-1:0] cc_act;
    logic [NCH-1:0][CNT_W-1:0] cc_pend;
    logic                      tgt_wr_act;
    logic                      tgt_wr_pend;
    logic [NCH-1:0]            cc_wr_act;
    logic [NCH-1:0]            cc_wr_pend;
    logic                      clr_tz;
    logic [NCH-1:0]            clr_cc;

    buf_tmr_regif #(.CNT_W(CNT_W), .NCH(NCH), .IDX_W(IDX_W)) regif_i (
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .tgt_act    (tgt_act),
        .tgt_pend   (tgt_pend),
        .cc_act     (cc_act),
        .cc_pend    (cc_pend),
        .wr_tgt_act (tgt_wr_act),
        .wr_tgt_pend(tgt_wr_pend),
        .wr_cc_act  (cc_wr_act),
        .wr_cc_pend (cc_wr_pend),
        .clr_tz     (clr_tz),
        .clr_cc     (clr_cc),
        .rdata      (rdata)
    );

    buf_tmr_count #(.CNT_W(CNT_W)) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .tgt_act  (tgt_act),
        .clr_tz   (clr_tz),
        .mode_q   (mode_q),
        .cnt      (cnt_o),
        .dir_down (dir_down_o),
        .tick_run (tick_run),
        .zc       (zc),
        .tgt_flag (tgt_flag_o),
        .zero_flag(zero_flag_o)
    );

    buf_tmr_shadow #(.CNT_W(CNT_W)) tgt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_act (tgt_wr_act),
        .wr_pend(tgt_wr_pend),
        .wdata  (wdata),
        .load   (zc),
        .flush  (mode_wr),
        .act    (tgt_act),
        .pend   (tgt_pend)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        buf_tmr_chan #(.CNT_W(CNT_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt_o),
            .tick_run(tick_run),
            .zc      (zc),
            .flush   (mode_wr),
            .wr_act  (cc_wr_act[i]),
            .wr_pend (cc_wr_pend[i]),
            .wdata   (wdata),
            .clr     (clr_cc[i]),
            .cc_act  (cc_act[i]),
            .cc_pend (cc_pend[i]),
            .evt     (cmp_evt_o[i]),
            .flag    (cmp_flag_o[i])
        );
    end
endmodule

// File: rtl/buf_tmr_chk.sv
// Property checker for buf_tmr, attached by bind. Observes ports and the
// active target and its direct-write strobe.
module buf_tmr_chk
    import buf_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NCH    = 3,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              mode_wr,
    input logic [1:0]        mode_val,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              dir_down_o,
    input logic              tgt_flag_o,
    input logic              zero_flag_o,
    input logic [NCH-1:0]    cmp_evt_o,
    input logic [CNT_W-1:0]  tgt_act,
    input logic              tgt_wr_act,
    input tmr_mode_e         mode_q
);
    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr && (mode_val != 2'd0) |=> (cnt_o == '0) && !dir_down_o);

    // R10
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !mode_wr |=> $stable(cnt_o));

    // R9
    evt_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmp_evt_o) |-> $past(tick_en));

    // R1
    tgt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt_act) |-> $past(tgt_wr_act) || (cnt_o == '0));

    // R5
    dir_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_TRI) |-> !dir_down_o);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && (addr == ADDR_W'(0)) && !tick_en) |-> !tgt_flag_o && !zero_flag_o);
endmodule

bind buf_tmr buf_tmr_chk #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .mode_wr    (mode_wr),
    .mode_val   (mode_val),
    .rd_en      (rd_en),
    .addr       (addr),
    .cnt_o      (cnt_o),
    .dir_down_o (dir_down_o),
    .tgt_flag_o (tgt_flag_o),
    .zero_flag_o(zero_flag_o),
    .cmp_evt_o  (cmp_evt_o),
    .tgt_act    (tgt_act),
    .tgt_wr_act (tgt_wr_act),
    .mode_q     (mode_q)
);

// File: tb/buf_tmr_tb_top.sv
// Self-checking bench for buf_tmr: a vector table of counting cases, then
// directed tests of buffering, flushing, flags and compare events.
module buf_tmr_tb_top;
    localparam int CNT_W = 16;
    localparam int NCH   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             mode_wr = 1'b0;
    logic [1:0]       mode_val = 2'd0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [3:0]       addr = 4'd0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic [CNT_W-1:0] cnt_o;
    logic             dir_down_o;
    logic             tgt_flag_o;
    logic             zero_flag_o;
    logic [NCH-1:0]   cmp_flag_o;
    logic [NCH-1:0]   cmp_evt_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    buf_tmr #(.CNT_W(CNT_W), .NCH(NCH)) dut_i (
        .clk, .rst_n, .tick_en, .mode_wr, .mode_val, .wr_en, .rd_en, .addr,
        .wdata, .rdata, .cnt_o, .dir_down_o, .tgt_flag_o, .zero_flag_o,
        .cmp_flag_o, .cmp_evt_o
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] tgt;
        logic [7:0] ticks;
        logic [7:0] cnt;
        logic       dir;
    } vec_t;

    // Counting cases: R5 wrap and reversal, R6 stop.
    localparam vec_t VECS [8] = '{
        '{2'd2, 8'd5, 8'd3,  8'd3, 1'b0},
        '{2'd2, 8'd5, 8'd6,  8'd0, 1'b0},
        '{2'd2, 8'd5, 8'd8,  8'd2, 1'b0},
        '{2'd1, 8'd4, 8'd10, 8'd4, 1'b0},
        '{2'd3, 8'd3, 8'd4,  8'd2, 1'b1},
        '{2'd3, 8'd3, 8'd5,  8'd1, 1'b1},
        '{2'd3, 8'd3, 8'd7,  8'd1, 1'b0},
        '{2'd3, 8'd0, 8'd4,  8'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [CNT_W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_val = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset state
        chk("R4 reset cnt", cnt_o, 0);
        chk("R4 reset dir", dir_down_o, 0);
        chk("R4 reset flags", {tgt_flag_o, zero_flag_o, cmp_flag_o}, 0);
        reg_rd(4'd8, rd);
        chk("R4 reset target", rd, 0);

        // R5 R6 vector table
        for (int v = 0; v < 8; v++) begin
            reg_wr(4'd0, CNT_W'(VECS[v].tgt));
            set_mode(VECS[v].mode);
            tick_n(int'(VECS[v].ticks));
            chk($sformatf("R5/R6 vec%0d cnt", v), cnt_o, VECS[v].cnt);
            chk($sformatf("R5 vec%0d dir", v), dir_down_o, VECS[v].dir);
        end

        // R1 buffered target load at zero crossing
        reg_wr(4'd0, 3);
        set_mode(2'd2);
        reg_wr(4'd1, 6);
        tick_n(3);
        reg_rd(4'd8, rd);
        chk("R1 no early load", rd, 3);
        tick_n(1);
        chk("R1 wrap cnt", cnt_o, 0);
        reg_rd(4'd8, rd);
        chk("R1 loaded at zero", rd, 6);
        tick_n(6);
        chk("R1 new period top", cnt_o, 6);
        reg_wr(4'd0, 4);
        tick_n(6);
        reg_rd(4'd8, rd);
        chk("R1 unwritten pending not reloaded", rd, 4);

        // R2 mode write restarts without copy and flushes
        reg_wr(4'd1, 2);
        reg_wr(4'd5, 9);
        set_mode(2'd2);
        reg_rd(4'd8, rd);
        chk("R2 restart no copy", rd, 4);
        tick_n(5);
        chk("R2 wrap cnt", cnt_o, 0);
        reg_rd(4'd8, rd);
        chk("R2 target load flushed", rd, 4);
        reg_rd(4'd10, rd);
        chk("R2 compare load flushed", rd, 0);

        // R3 compare load at zero crossing; none while disabled
        reg_wr(4'd6, 3);
        reg_rd(4'd11, rd);
        chk("R3 compare before wrap", rd, 0);
        tick_n(5);
        reg_rd(4'd11, rd);
        chk("R3 compare loaded", rd, 3);
        tick_n(2);
        set_mode(2'd0);
        reg_wr(4'd7, 7);
        tick_n(10);
        chk("R3 disabled holds cnt", cnt_o, 2);
        reg_rd(4'd12, rd);
        chk("R3 no load while disabled", rd, 0);

        // R10 no advance without tick
        set_mode(2'd2);
        repeat (5) @(negedge clk);
        chk("R10 idle cnt", cnt_o, 0);
        tick_n(2);
        repeat (3) @(negedge clk);
        chk("R10 holds after ticks", cnt_o, 2);

        // R7 R8 flags and aliases
        reg_wr(4'd0, 2);
        set_mode(2'd2);
        chk("R8 flags cleared by write", {tgt_flag_o, zero_flag_o}, 0);
        tick_n(1);
        chk("R7 zero flag", zero_flag_o, 1);
        chk("R7 no target flag", tgt_flag_o, 0);
        reg_rd(4'd9, rd);
        chk("R8 alias read keeps zero flag", zero_flag_o, 1);
        reg_rd(4'd1, rd);
        chk("R8 clearing read", zero_flag_o, 0);
        tick_n(2);
        chk("R7 target flag", tgt_flag_o, 1);
        chk("R7 zero flag not set", zero_flag_o, 0);
        reg_wr(4'd8, 2);
        chk("R8 alias write keeps target flag", tgt_flag_o, 1);
        reg_rd(4'd0, rd);
        chk("R8 clearing read target", tgt_flag_o, 0);

        // R9 compare event one tick after match
        reg_wr(4'd0, 5);
        reg_wr(4'd2, 2);
        set_mode(2'd2);
        tick_n(3);
        chk("R9 no event at match tick", cmp_evt_o[0], 0);
        tick_n(1);
        chk("R9 event next tick", cmp_evt_o[0], 1);
        chk("R9 flag set", cmp_flag_o[0], 1);
        @(negedge clk);
        chk("R9 single pulse", cmp_evt_o[0], 0);
        reg_rd(4'd10, rd);
        chk("R9 alias keeps flag", cmp_flag_o[0], 1);
        reg_rd(4'd2, rd);
        chk("R9 clearing read", cmp_flag_o[0], 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule